// File: doc/BRIEF.md
# Exception entry sequencer

This block carries out the hardware part of taking an exception on a 32-bit RISC core. It accepts five kinds of request: power-on reset, manual reset, address error, instruction exception and interrupt. An interrupt request comes with a priority level and a vector number. When it accepts a request, the block captures the core's PC, SR, stack pointer (R15) and vector base (VBR). It then runs a short series of single-word accesses on its memory port and hands the core a new PC, SP, VBR and SR.

A reset reads two words from a fixed table slot: the first becomes the new PC and the second the new SP. VBR is cleared and every SR interrupt-mask bit is set. Any other exception first pushes SR and then PC onto the stack below R15. It then reads the handler address from the vector base plus four times the vector number. An interrupt also writes its priority level into the SR mask. An address error or instruction exception leaves SR untouched.

The controller is a state machine with six states. ST_IDLE waits for a request. ST_RST_PC and ST_RST_SP are the two reset table reads. ST_PUSH_SR and ST_PUSH_PC are the two stack writes. ST_VEC_RD is the handler fetch. The transitions are:
- IDLE→RST_PC on a reset request.
- IDLE→PUSH_SR on any other request.
- RST_PC→RST_SP, PUSH_SR→PUSH_PC and PUSH_PC→VEC_RD each on a completed access.
- RST_SP→IDLE and VEC_RD→IDLE on the final completed access, which raises `done`.
- Any state→RST_PC whenever a reset request is present (abort).

Top module: `exc_entry_seq`

## Requirements
- R1: After `rst_n` is released, `busy`, `done` and `mem_req` are low and `pc_out`, `sp_out`, `vbr_out` and `sr_out` are all zero.
- R2: A power-on reset request performs a read at 0x0 and then a read at 0x4. The first word read becomes `pc_out` and the second becomes `sp_out`.
- R3: A manual reset request performs a read at 0x8 and then a read at 0xC, loading PC and SP the same way as R2.
- R4: When a reset completes, `vbr_out` is zero, `sr_out[7:4]` (the interrupt mask) is 4'b1111, and every other SR bit equals `core_sr` as captured when the request was accepted.
- R5: A non-reset exception writes the captured SR to R15−4, then writes the captured PC to R15−8. `sp_out` becomes R15−8.
- R6: After the two pushes, the handler PC is read from VBR + 4·vector. The vector is `instr_vec` for an instruction exception (4 selects offset 0x10), `irq_vec` for an interrupt, and the parameter `AERR_VEC` for an address error. `vbr_out` keeps the captured VBR.
- R7: An interrupt sets `sr_out[7:4]` to `irq_lvl`. An address error or instruction exception returns SR unchanged.
- R8: When requests arrive together, the priority order is power-on reset, then manual reset, then address error, then instruction exception, then interrupt.
- R9: Only one access is outstanding at a time. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` are held steady until `mem_rdy` is seen, whatever the number of wait cycles.
- R10: A non-reset request that arrives while `busy` is high is ignored: it produces no access and no `done`.
- R11: A reset request arriving in the middle of any sequence abandons that sequence and starts the reset sequence. Only the reset then produces `done`.
- R12: `done` is high for exactly one cycle, in the cycle when the outputs carry the new values. The outputs then hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_req | input | 1 | Power-on reset request |
| mrst_req | input | 1 | Manual reset request |
| aerr_req | input | 1 | Address-error exception request |
| instr_req | input | 1 | Instruction exception request |
| instr_vec | input | 8 | Vector number of the instruction exception |
| irq_req | input | 1 | Interrupt request |
| irq_lvl | input | 4 | Priority level of the accepted interrupt |
| irq_vec | input | 8 | Vector number of the interrupt |
| core_pc | input | 32 | Current PC (return address) |
| core_sr | input | 32 | Current status register |
| core_sp | input | 32 | Current R15 |
| core_vbr | input | 32 | Current vector base |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: new values are valid |
| pc_out | output | 32 | New PC |
| sp_out | output | 32 | New R15 |
| vbr_out | output | 32 | New VBR |
| sr_out | output | 32 | New SR |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Access completes on a clock edge where `mem_req` and `mem_rdy` are both high |

## Verification
The bench builds the block with a 32-bit data path, an 8-bit vector field, a 4-bit level with the mask at bit 4, and `AERR_VEC` set to 9. The 8-bit vector width makes vector 255 reachable, so the bench can drive the highest table slot at VBR+0x3FC. The 4-bit level lets it check that the surrounding SR bits survive a mask rewrite. The bench's memory model can insert zero or three wait cycles per access. The longer setting keeps a sequence in flight long enough for a reset to abort it between stack pushes.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_POR,
        CLS_MRST,
        CLS_AERR,
        CLS_INSTR,
        CLS_IRQ
    } exc_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_PC,
        ST_RST_SP,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_VEC_RD
    } seq_st_e;

endpackage

// File: rtl/exc_req_arb.sv
module exc_req_arb
    import exc_entry_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int LVL_W    = 4,
    parameter int AERR_VEC = 9
) (
    input  logic             por_req,
    input  logic             mrst_req,
    input  logic             aerr_req,
    input  logic             instr_req,
    input  logic [VEC_W-1:0] instr_vec,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic [VEC_W-1:0] irq_vec,
    output exc_cls_e         cls_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic             is_rst_o
);

    localparam logic [VEC_W-1:0] AERR_V = VEC_W'(AERR_VEC);

    // Fixed priority: power-on, manual, address error, instruction, interrupt
    always_comb begin
        cls_o = CLS_NONE;
        vec_o = '0;
        lvl_o = '0;
        if (por_req) begin
            cls_o = CLS_POR;
        end else if (mrst_req) begin
            cls_o = CLS_MRST;
        end else if (aerr_req) begin
            cls_o = CLS_AERR;
            vec_o = AERR_V;
        end else if (instr_req) begin
            cls_o = CLS_INSTR;
            vec_o = instr_vec;
        end else if (irq_req) begin
            cls_o = CLS_IRQ;
            vec_o = irq_vec;
            lvl_o = irq_lvl;
        end
    end

    assign is_rst_o = por_req | mrst_req;

    // R8
    always_comb begin
        if (por_req) begin
            por_wins_chk: assert (cls_o == CLS_POR);
        end
    end

endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
    import exc_entry_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                VEC_W     = 8,
    parameter logic [DATA_W-1:0] POR_BASE  = '0,
    parameter logic [DATA_W-1:0] MRST_BASE = DATA_W'(8)
) (
    input  seq_st_e           st,
    input  logic              use_mrst,
    input  logic [DATA_W-1:0] sp_cap,
    input  logic [DATA_W-1:0] pc_cap,
    input  logic [DATA_W-1:0] sr_cap,
    input  logic [DATA_W-1:0] vbr_cap,
    input  logic [VEC_W-1:0]  vec_cap,
    output logic              req,
    output logic              we,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    localparam int                WORD_BYTES = DATA_W / 8;
    localparam int                VEC_SH     = $clog2(WORD_BYTES);
    localparam logic [DATA_W-1:0] STEP       = DATA_W'(WORD_BYTES);

    logic [DATA_W-1:0] tbl_base;
    logic [DATA_W-1:0] vec_off;

    assign tbl_base = use_mrst ? MRST_BASE : POR_BASE;
    assign vec_off  = DATA_W'(vec_cap) << VEC_SH;

    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        unique case (st)
            ST_IDLE: begin
                req = 1'b0;
            end
            ST_RST_PC: begin
                addr = tbl_base;
            end
            ST_RST_SP: begin
                addr = tbl_base + STEP;
            end
            ST_PUSH_SR: begin
                we    = 1'b1;
                addr  = sp_cap - STEP;
                wdata = sr_cap;
            end
            ST_PUSH_PC: begin
                we    = 1'b1;
                addr  = sp_cap - (STEP << 1);
                wdata = pc_cap;
            end
            ST_VEC_RD: begin
                addr = vbr_cap + vec_off;
            end
            default: begin
                req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/exc_sr_merge.sv
module exc_sr_merge
    import exc_entry_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LVL_W     = 4,
    parameter int IMASK_LSB = 4
) (
    input  exc_cls_e          cls,
    input  logic [DATA_W-1:0] sr_i,
    input  logic [LVL_W-1:0]  lvl,
    output logic [DATA_W-1:0] sr_o
);

    localparam int MSK_HI = IMASK_LSB + LVL_W - 1;

    logic set_all;
    logic take_lvl;

    assign set_all  = (cls == CLS_POR) || (cls == CLS_MRST);
    assign take_lvl = (cls == CLS_IRQ);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b >= IMASK_LSB && b <= MSK_HI) begin : g_mask
            assign sr_o[b] = set_all ? 1'b1 : (take_lvl ? lvl[b-IMASK_LSB] : sr_i[b]);
        end else begin : g_keep
            assign sr_o[b] = sr_i[b];
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                VEC_W     = 8,
    parameter int                LVL_W     = 4,
    parameter int                IMASK_LSB = 4,
    parameter int                AERR_VEC  = 9,
    parameter logic [DATA_W-1:0] POR_BASE  = '0,
    parameter logic [DATA_W-1:0] MRST_BASE = DATA_W'(8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_req,
    input  logic              mrst_req,
    input  logic              aerr_req,
    input  logic              instr_req,
    input  logic [VEC_W-1:0]  instr_vec,
    input  logic              irq_req,
    input  logic [LVL_W-1:0]  irq_lvl,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [DATA_W-1:0] core_pc,
    input  logic [DATA_W-1:0] core_sr,
    input  logic [DATA_W-1:0] core_sp,
    input  logic [DATA_W-1:0] core_vbr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] vbr_out,
    output logic [DATA_W-1:0] sr_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy
);

    localparam int                WORD_BYTES = DATA_W / 8;
    localparam logic [DATA_W-1:0] PUSH_SPAN  = DATA_W'(2 * WORD_BYTES);
    localparam int                MSK_HI     = IMASK_LSB + LVL_W - 1;

    seq_st_e           st_q, st_d;
    exc_cls_e          arb_cls, cls_q;
    logic [VEC_W-1:0]  arb_vec, vec_q;
    logic [LVL_W-1:0]  arb_lvl, lvl_q;
    logic              arb_rst;
    logic [DATA_W-1:0] pc_q, sr_q, sp_q, vbr_q, pc_tmp, sr_new;
    logic              hs, load, fin, cls_rst;

    exc_req_arb #(
        .VEC_W   (VEC_W),
        .LVL_W   (LVL_W),
        .AERR_VEC(AERR_VEC)
    ) arb_i (
        .por_req  (por_req),
        .mrst_req (mrst_req),
        .aerr_req (aerr_req),
        .instr_req(instr_req),
        .instr_vec(instr_vec),
        .irq_req  (irq_req),
        .irq_lvl  (irq_lvl),
        .irq_vec  (irq_vec),
        .cls_o    (arb_cls),
        .vec_o    (arb_vec),
        .lvl_o    (arb_lvl),
        .is_rst_o (arb_rst)
    );

    exc_addr_gen #(
        .DATA_W   (DATA_W),
        .VEC_W    (VEC_W),
        .POR_BASE (POR_BASE),
        .MRST_BASE(MRST_BASE)
    ) agen_i (
        .st      (st_q),
        .use_mrst(cls_q == CLS_MRST),
        .sp_cap  (sp_q),
        .pc_cap  (pc_q),
        .sr_cap  (sr_q),
        .vbr_cap (vbr_q),
        .vec_cap (vec_q),
        .req     (mem_req),
        .we      (mem_we),
        .addr    (mem_addr),
        .wdata   (mem_wdata)
    );

    exc_sr_merge #(
        .DATA_W   (DATA_W),
        .LVL_W    (LVL_W),
        .IMASK_LSB(IMASK_LSB)
    ) srm_i (
        .cls (cls_q),
        .sr_i(sr_q),
        .lvl (lvl_q),
        .sr_o(sr_new)
    );

    assign hs      = mem_req && mem_rdy;
    assign cls_rst = (cls_q == CLS_POR) || (cls_q == CLS_MRST);
    assign load    = arb_rst || ((st_q == ST_IDLE) && (arb_cls != CLS_NONE));
    assign fin     = hs && !arb_rst && ((st_q == ST_RST_SP) || (st_q == ST_VEC_RD));
    assign busy    = (st_q != ST_IDLE);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (arb_rst) begin
            st_d = ST_RST_PC;
        end else begin
            unique case (st_q)
                ST_IDLE:    if (arb_cls != CLS_NONE) st_d = ST_PUSH_SR;
                ST_RST_PC:  if (hs) st_d = ST_RST_SP;
                ST_RST_SP:  if (hs) st_d = ST_IDLE;
                ST_PUSH_SR: if (hs) st_d = ST_PUSH_PC;
                ST_PUSH_PC: if (hs) st_d = ST_VEC_RD;
                ST_VEC_RD:  if (hs) st_d = ST_IDLE;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Capture and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q   <= CLS_NONE;
            vec_q   <= '0;
            lvl_q   <= '0;
            pc_q    <= '0;
            sr_q    <= '0;
            sp_q    <= '0;
            vbr_q   <= '0;
            pc_tmp  <= '0;
            done    <= 1'b0;
            pc_out  <= '0;
            sp_out  <= '0;
            vbr_out <= '0;
            sr_out  <= '0;
        end else begin
            done <= fin;
            if (load) begin
                cls_q <= arb_cls;
                vec_q <= arb_vec;
                lvl_q <= arb_lvl;
                pc_q  <= core_pc;
                sr_q  <= core_sr;
                sp_q  <= core_sp;
                vbr_q <= core_vbr;
            end
            if (hs && (st_q == ST_RST_PC)) begin
                pc_tmp <= mem_rdata;
            end
            if (fin) begin
                sr_out <= sr_new;
                if (cls_rst) begin
                    pc_out  <= pc_tmp;
                    sp_out  <= mem_rdata;
                    vbr_out <= '0;
                end else begin
                    pc_out  <= mem_rdata;
                    sp_out  <= sp_q - PUSH_SPAN;
                    vbr_out <= vbr_q;
                end
            end
        end
    end

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy && !por_req && !mrst_req) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !por_req && !mrst_req) |=> $stable(cls_q));

    // R4
    rst_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls_rst) |-> ((vbr_out == '0) && (&sr_out[MSK_HI:IMASK_LSB])));

endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        string       tag;
    } acc_t;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] sp;
        logic [31:0] vbr;
        logic [31:0] sr;
        string       tag;
    } res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_req = 0, mrst_req = 0, aerr_req = 0, instr_req = 0, irq_req = 0;
    logic [7:0]  instr_vec = '0, irq_vec = '0;
    logic [3:0]  irq_lvl = '0;
    logic [31:0] core_pc = '0, core_sr = '0, core_sp = '0, core_vbr = '0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] pc_out, sp_out, vbr_out, sr_out, mem_addr, mem_wdata, mem_rdata;
    logic        mem_rdy = 1'b0;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    bit chk_acc = 1'b1;
    bit prev_done = 1'b0;
    acc_t exp_acc[$];
    res_t exp_res[$];

    always #2 clk = ~clk;

    function automatic logic [31:0] mdl(input logic [31:0] a);
        return (a ^ 32'hC0DE_0000) + 32'h0000_1234;
    endfunction

    assign mem_rdata = mdl(mem_addr);

    exc_entry_seq #(.AERR_VEC(9)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .por_req(por_req), .mrst_req(mrst_req), .aerr_req(aerr_req),
        .instr_req(instr_req), .instr_vec(instr_vec),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec),
        .core_pc(core_pc), .core_sr(core_sr), .core_sp(core_sp), .core_vbr(core_vbr),
        .busy(busy), .done(done),
        .pc_out(pc_out), .sp_out(sp_out), .vbr_out(vbr_out), .sr_out(sr_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Memory model and monitor
    always @(negedge clk) begin
        if (mem_rdy) begin
            mem_rdy = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= wait_cfg) mem_rdy = 1'b1;
            else wcnt++;
        end else begin
            wcnt = 0;
        end
        if (mem_req && mem_rdy && chk_acc) begin
            if (exp_acc.size() == 0) begin
                check(1'b0, "R10 unexpected access", mem_addr, 32'h0);
            end else begin
                acc_t e;
                e = exp_acc.pop_front();
                check(mem_we == e.we, {e.tag, " we"}, 32'(mem_we), 32'(e.we));
                check(mem_addr == e.addr, {e.tag, " addr"}, mem_addr, e.addr);
                if (e.we) check(mem_wdata == e.wdata, {e.tag, " wdata"}, mem_wdata, e.wdata);
            end
        end
        if (done) begin
            done_cnt++;
            check(!prev_done, "R12 done longer than one cycle", 32'd1, 32'd0);
            if (exp_res.size() == 0) begin
                check(1'b0, "R10 unexpected done", pc_out, 32'h0);
            end else begin
                res_t r;
                r = exp_res.pop_front();
                check(pc_out == r.pc, {r.tag, " pc"}, pc_out, r.pc);
                check(sp_out == r.sp, {r.tag, " sp"}, sp_out, r.sp);
                check(vbr_out == r.vbr, {r.tag, " vbr"}, vbr_out, r.vbr);
                check(sr_out == r.sr, {r.tag, " sr"}, sr_out, r.sr);
            end
        end
        prev_done = done;
    end

    task automatic exp_reset(input logic [31:0] base, input bit with_acc, input string tag);
        res_t r;
        if (with_acc) begin
            exp_acc.push_back('{1'b0, base, 32'h0, tag});
            exp_acc.push_back('{1'b0, base + 32'd4, 32'h0, tag});
        end
        r = '{mdl(base), mdl(base + 32'd4), 32'h0, core_sr | 32'h0000_00F0, {tag, " R4"}};
        exp_res.push_back(r);
    endtask

    task automatic exp_exc(input logic [7:0] vec, input bit is_irq, input logic [3:0] lvl, input string tag);
        logic [31:0] h;
        logic [31:0] s;
        res_t r;
        h = core_vbr + {22'h0, vec, 2'b00};
        s = is_irq ? ((core_sr & ~32'h0000_00F0) | {24'h0, lvl, 4'h0}) : core_sr;
        exp_acc.push_back('{1'b1, core_sp - 32'd4, core_sr, {tag, " R5 push SR"}});
        exp_acc.push_back('{1'b1, core_sp - 32'd8, core_pc, {tag, " R5 push PC"}});
        exp_acc.push_back('{1'b0, h, 32'h0, {tag, " R6 handler read"}});
        r = '{mdl(h), core_sp - 32'd8, core_vbr, s, {tag, " R7"}};
        exp_res.push_back(r);
    endtask

    task automatic fire(input bit p, input bit m, input bit a, input bit i, input bit q);
        @(negedge clk);
        por_req = p; mrst_req = m; aerr_req = a; instr_req = i; irq_req = q;
        @(negedge clk);
        por_req = 0; mrst_req = 0; aerr_req = 0; instr_req = 0; irq_req = 0;
    endtask

    task automatic wait_done(input int start, input string tag);
        int t = 0;
        while (done_cnt == start && t < 500) begin
            @(negedge clk);
            t++;
        end
        check(done_cnt != start, {tag, " done never seen"}, 32'(done_cnt), 32'(start + 1));
        repeat (2) @(negedge clk);
    endtask

    task automatic core_state(input logic [31:0] pc, input logic [31:0] sr,
                              input logic [31:0] sp, input logic [31:0] vbr);
        core_pc = pc; core_sr = sr; core_sp = sp; core_vbr = vbr;
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog expired");
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !mem_req, "R1 control outputs", {29'h0, busy, done, mem_req}, 32'h0);
        check((pc_out | sp_out | vbr_out | sr_out) == 32'h0, "R1 value outputs", pc_out | sp_out | vbr_out | sr_out, 32'h0);

        // R2 power-on reset
        core_state(32'h1111_2220, 32'h4000_0301, 32'h0000_9000, 32'h0000_2000);
        s = done_cnt; exp_reset(32'h0, 1, "R2"); fire(1, 0, 0, 0, 0); wait_done(s, "R2");
        check(!done, "R12 done dropped", {31'h0, done}, 32'h0);

        // R3 manual reset
        core_state(32'h1111_2220, 32'h0000_000C, 32'h0000_9000, 32'h0000_2000);
        s = done_cnt; exp_reset(32'h8, 1, "R3"); fire(0, 1, 0, 0, 0); wait_done(s, "R3");

        // R7 interrupt level 5, vector 0x40
        core_state(32'h0000_4A00, 32'h8000_0F31, 32'h0000_8000, 32'h0000_1000);
        s = done_cnt; irq_lvl = 4'h5; irq_vec = 8'h40;
        exp_exc(8'h40, 1, 4'h5, "R7 irq"); fire(0, 0, 0, 0, 1); wait_done(s, "R7 irq");

        // R6 address error uses the fixed vector 9
        core_state(32'h0000_5B02, 32'h0000_00A0, 32'h0001_0000, 32'h0400_0000);
        s = done_cnt; exp_exc(8'd9, 0, 4'h0, "R6 aerr"); fire(0, 0, 1, 0, 0); wait_done(s, "R6 aerr");

        // R6 general illegal instruction, vector 4 -> offset 0x10
        s = done_cnt; instr_vec = 8'd4;
        exp_exc(8'd4, 0, 4'h0, "R6 illegal"); fire(0, 0, 0, 1, 0); wait_done(s, "R6 illegal");

        // R6 top table slot with three wait cycles (R9)
        wait_cfg = 3;
        s = done_cnt; instr_vec = 8'hFF;
        exp_exc(8'hFF, 0, 4'h0, "R9 vec255"); fire(0, 0, 0, 1, 0); wait_done(s, "R9 vec255");
        wait_cfg = 0;

        // R8 priorities
        core_state(32'h0000_7000, 32'h0000_0050, 32'h0000_6000, 32'h0000_3000);
        irq_lvl = 4'hE; irq_vec = 8'h21; instr_vec = 8'h06;
        s = done_cnt; exp_exc(8'd9, 0, 4'h0, "R8 aerr wins"); fire(0, 0, 1, 1, 1); wait_done(s, "R8 aerr wins");
        s = done_cnt; exp_exc(8'h06, 0, 4'h0, "R8 instr wins"); fire(0, 0, 0, 1, 1); wait_done(s, "R8 instr wins");
        s = done_cnt; exp_reset(32'h8, 1, "R8 mrst wins"); fire(0, 1, 1, 0, 1); wait_done(s, "R8 mrst wins");
        s = done_cnt; exp_reset(32'h0, 1, "R8 por wins"); fire(1, 1, 0, 0, 1); wait_done(s, "R8 por wins");

        // R10 request while busy is ignored
        core_state(32'h0000_7000, 32'h0000_0000, 32'h0000_6000, 32'h0000_3000);
        irq_lvl = 4'h3; irq_vec = 8'h30;
        s = done_cnt; exp_exc(8'h30, 1, 4'h3, "R10 first");
        fire(0, 0, 0, 0, 1); fire(0, 0, 1, 0, 0);
        wait_done(s, "R10 first");
        repeat (30) @(negedge clk);
        check(done_cnt == s + 1, "R10 done count", 32'(done_cnt), 32'(s + 1));
        check(!busy, "R10 idle after", {31'h0, busy}, 32'h0);
        check(exp_acc.size() == 0, "R10 leftover accesses", 32'(exp_acc.size()), 32'h0);

        // R11 reset aborts an interrupt sequence
        chk_acc = 1'b0; wait_cfg = 3;
        core_state(32'h0000_7700, 32'h0000_0010, 32'h0000_6000, 32'h0000_3000);
        s = done_cnt;
        fire(0, 0, 0, 0, 1);
        repeat (5) @(negedge clk);
        check(busy, "R11 busy before abort", {31'h0, busy}, 32'h1);
        exp_reset(32'h0, 0, "R11 abort");
        fire(1, 0, 0, 0, 0);
        wait_done(s, "R11 abort");
        repeat (20) @(negedge clk);
        check(done_cnt == s + 1, "R11 done count", 32'(done_cnt), 32'(s + 1));
        chk_acc = 1'b1; wait_cfg = 0;
        exp_acc.delete();

        // R12 outputs hold after done
        check(pc_out == mdl(32'h0) && vbr_out == 32'h0, "R12 outputs held", pc_out, mdl(32'h0));
        check(exp_res.size() == 0, "R12 missing done", 32'(exp_res.size()), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule